// File: doc/BRIEF.md
# Output Virtual-Channel State and Credit Tracker

This block sits on one output port of a virtual-channel router. For every downstream virtual channel (VC) it keeps two pieces of state: whether the VC is idle or held by a packet, and how many buffer slots remain free in the next hop. The VCs are split into equal-sized groups, one group per virtual network. VC `v*VCS_PER_VNET + k` belongs to virtual network `v`.

An allocator presents a virtual network number on `query_vnet`. The block answers combinationally whether that network has an idle VC, and which one it would hand out. Pulsing `alloc_req` claims that VC for a head flit, and the index on `sel_idx` travels with the flit as its next-hop VC. Every flit sent downstream consumes one credit through `dec_valid`/`dec_vc`. Credits come back on `ret_valid`/`ret_vc`. A return with `ret_free` set belongs to a tail or single-flit packet and also releases the VC.

All state is registered. The query outputs are combinational from that state and `query_vnet`.

Top module: `ovc_tracker`

## Requirements
- R1: After reset every VC is idle (`vc_busy` all 0), every credit count equals `BUF_DEPTH`, `credit_avail` is all 1 and `err` is 0.
- R2: `any_free` is 1 exactly when some VC with index in `[query_vnet*VCS_PER_VNET, query_vnet*VCS_PER_VNET+VCS_PER_VNET-1]` is idle. The state of VCs outside that range has no effect.
- R3: `sel_idx` is the lowest-index idle VC in the queried range, and `sel_valid` equals `any_free`. When `sel_valid` is 0, no VC in the range is idle.
- R4: `alloc_req` while `sel_valid` is 1 makes VC `sel_idx` busy from the next cycle. `alloc_req` while `sel_valid` is 0 changes no state.
- R5: Each `dec_valid` lowers the count of VC `dec_vc` by one, whatever kind of flit caused it. The count of VC i is `credit_cnt[i*CW +: CW]`, and `credit_avail[i]` is 1 exactly when that count is non-zero.
- R6: Each `ret_valid` raises the count of VC `ret_vc` by one. With `ret_free` = 1 the VC also becomes idle. With `ret_free` = 0 its busy/idle state is unchanged.
- R7: A decrement and a credit return aimed at the same VC in the same cycle leave its count unchanged, and a free flag on that return still idles the VC.
- R8: A decrement at count 0 leaves the count at 0, and a return at count `BUF_DEPTH` leaves it at `BUF_DEPTH`. Either event sets `err` to 1 for exactly the following cycle.
- R9: If an allocation and a freeing return name the same VC in the same cycle, the VC ends busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| query_vnet | input | VNW | Virtual network being asked about |
| any_free | output | 1 | Some VC of the queried network is idle |
| sel_valid | output | 1 | `sel_idx` names an idle VC |
| sel_idx | output | VCW | Lowest idle VC in the queried network |
| alloc_req | input | 1 | Claim the VC on `sel_idx` |
| dec_valid | input | 1 | A flit was granted onto `dec_vc` |
| dec_vc | input | VCW | VC whose credit is consumed |
| ret_valid | input | 1 | A credit returns from downstream |
| ret_vc | input | VCW | VC the credit belongs to |
| ret_free | input | 1 | Returned credit also releases the VC |
| vc_busy | output | NUM_VCS | Per-VC allocated flag |
| credit_avail | output | NUM_VCS | Per-VC credit non-zero |
| credit_cnt | output | NUM_VCS*CW | Packed per-VC credit counts |
| err | output | 1 | Credit overflow or underflow in the previous cycle |

## Verification
A VC can be debited for an outgoing flit in the same cycle that a credit for it comes back from downstream. An allocation can also land on a VC in the cycle that a freeing return names it. The bench drives both coincidences on purpose: it pulses decrement and return together on one VC, with and without the free flag, and it pairs an allocation with a freeing return to the same VC. In each case it compares the count, the busy bit and `err` on the following cycle against the net-zero and busy-wins rules.

// File: rtl/ovc_pkg.sv
package ovc_pkg;

    typedef enum logic {
        VC_IDLE   = 1'b0,
        VC_ACTIVE = 1'b1
    } vc_state_e;

    typedef enum logic [1:0] {
        CTR_HOLD = 2'd0,
        CTR_DOWN = 2'd1,
        CTR_UP   = 2'd2
    } ctr_op_e;

    function automatic ctr_op_e ctr_decode(input logic up, input logic down);
        if (up && !down) return CTR_UP;
        if (down && !up) return CTR_DOWN;
        return CTR_HOLD;
    endfunction

    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ovc_pick.sv
module ovc_pick #(
    parameter int NUM_VNETS    = 2,
    parameter int VCS_PER_VNET = 2,
    localparam int NUM_VCS     = NUM_VNETS * VCS_PER_VNET,
    localparam int VNW         = ovc_pkg::width_of(NUM_VNETS),
    localparam int VCW         = ovc_pkg::width_of(NUM_VCS)
) (
    input  logic [NUM_VCS-1:0] busy_i,
    input  logic [VNW-1:0]     vnet_i,
    output logic               any_o,
    output logic [VCW-1:0]     idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        if (int'(vnet_i) < NUM_VNETS) begin
            for (int k = VCS_PER_VNET - 1; k >= 0; k--) begin
                if (!busy_i[int'(vnet_i) * VCS_PER_VNET + k]) begin
                    any_o = 1'b1;
                    idx_o = VCW'(int'(vnet_i) * VCS_PER_VNET + k);
                end
            end
        end
    end
endmodule

// File: rtl/ovc_credit_ctr.sv
module ovc_credit_ctr #(
    parameter int BUF_DEPTH = 3,
    localparam int CW       = $clog2(BUF_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up_i,
    input  logic          down_i,
    output logic [CW-1:0] cnt_o,
    output logic          avail_o,
    output logic          err_o
);
    import ovc_pkg::*;

    ctr_op_e       op;
    logic [CW-1:0] cnt_q;
    logic          err_q;

    always_comb op = ctr_decode(up_i, down_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CW'(BUF_DEPTH);
            err_q <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (op)
                CTR_UP: begin
                    if (cnt_q == CW'(BUF_DEPTH)) err_q <= 1'b1;
                    else                         cnt_q <= cnt_q + 1'b1;
                end
                CTR_DOWN: begin
                    if (cnt_q == '0) err_q <= 1'b1;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign cnt_o   = cnt_q;
    assign avail_o = (cnt_q != '0);
    assign err_o   = err_q;

    // R7
    both_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (up_i && down_i) |=> $stable(cnt_q));
    // R8
    underflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (down_i && !up_i && cnt_q == '0) |=> (err_q && cnt_q == '0));
    // R8
    overflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (up_i && !down_i && cnt_q == CW'(BUF_DEPTH)) |=> (err_q && cnt_q == CW'(BUF_DEPTH)));
    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(BUF_DEPTH));
endmodule

// File: rtl/ovc_vc_state.sv
module ovc_vc_state #(
    parameter int NUM_VCS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VCS-1:0] claim_i,
    input  logic [NUM_VCS-1:0] release_i,
    output logic [NUM_VCS-1:0] busy_o
);
    import ovc_pkg::*;

    vc_state_e st_q [NUM_VCS];

    for (genvar i = 0; i < NUM_VCS; i++) begin : g_vc
        always_ff @(posedge clk) begin
            if (rst)               st_q[i] <= VC_IDLE;
            else if (claim_i[i])   st_q[i] <= VC_ACTIVE;
            else if (release_i[i]) st_q[i] <= VC_IDLE;
        end
        assign busy_o[i] = (st_q[i] == VC_ACTIVE);

        // R4
        claim_sets_chk: assert property (@(posedge clk) disable iff (rst)
            claim_i[i] |=> busy_o[i]);
        // R6
        release_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (release_i[i] && !claim_i[i]) |=> !busy_o[i]);
    end
endmodule

// File: rtl/ovc_tracker.sv
module ovc_tracker #(
    parameter int NUM_VNETS    = 2,
    parameter int VCS_PER_VNET = 2,
    parameter int BUF_DEPTH    = 3,
    localparam int NUM_VCS     = NUM_VNETS * VCS_PER_VNET,
    localparam int VNW         = ovc_pkg::width_of(NUM_VNETS),
    localparam int VCW         = ovc_pkg::width_of(NUM_VCS),
    localparam int CW          = $clog2(BUF_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [VNW-1:0]        query_vnet,
    output logic                  any_free,
    output logic                  sel_valid,
    output logic [VCW-1:0]        sel_idx,
    input  logic                  alloc_req,
    input  logic                  dec_valid,
    input  logic [VCW-1:0]        dec_vc,
    input  logic                  ret_valid,
    input  logic [VCW-1:0]        ret_vc,
    input  logic                  ret_free,
    output logic [NUM_VCS-1:0]    vc_busy,
    output logic [NUM_VCS-1:0]    credit_avail,
    output logic [NUM_VCS*CW-1:0] credit_cnt,
    output logic                  err
);
    logic               pick_any;
    logic [VCW-1:0]     pick_idx;
    logic [NUM_VCS-1:0] claim_vec, release_vec, err_vec;

    ovc_pick #(
        .NUM_VNETS   (NUM_VNETS),
        .VCS_PER_VNET(VCS_PER_VNET)
    ) u_pick (
        .busy_i (vc_busy),
        .vnet_i (query_vnet),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    assign any_free  = pick_any;
    assign sel_valid = pick_any;
    assign sel_idx   = pick_idx;

    for (genvar i = 0; i < NUM_VCS; i++) begin : g_lane
        logic up_hit, down_hit;
        assign up_hit         = ret_valid && (ret_vc == VCW'(i));
        assign down_hit       = dec_valid && (dec_vc == VCW'(i));
        assign claim_vec[i]   = alloc_req && pick_any && (pick_idx == VCW'(i));
        assign release_vec[i] = up_hit && ret_free;

        ovc_credit_ctr #(.BUF_DEPTH(BUF_DEPTH)) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .up_i    (up_hit),
            .down_i  (down_hit),
            .cnt_o   (credit_cnt[i*CW +: CW]),
            .avail_o (credit_avail[i]),
            .err_o   (err_vec[i])
        );
    end

    ovc_vc_state #(.NUM_VCS(NUM_VCS)) u_state (
        .clk       (clk),
        .rst       (rst),
        .claim_i   (claim_vec),
        .release_i (release_vec),
        .busy_o    (vc_busy)
    );

    assign err = |err_vec;

    // R3
    no_busy_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && sel_valid) |-> !vc_busy[sel_idx]);
    // R2
    sel_range_chk: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> (int'(sel_idx) / VCS_PER_VNET == int'(query_vnet)));
    // R4
    alloc_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(claim_vec));
endmodule

// File: tb/sim_ovc_tracker.sv
`timescale 1ns/1ps
module sim_ovc_tracker;
    localparam int NV = 2, VPV = 2, DEP = 3;
    localparam int NVC = NV * VPV, CW = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic [0:0] query_vnet = '0;
    logic any_free, sel_valid;
    logic [1:0] sel_idx;
    logic alloc_req = 0, dec_valid = 0, ret_valid = 0, ret_free = 0;
    logic [1:0] dec_vc = '0, ret_vc = '0;
    logic [NVC-1:0] vc_busy, credit_avail;
    logic [NVC*CW-1:0] credit_cnt;
    logic err;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    ovc_tracker #(.NUM_VNETS(NV), .VCS_PER_VNET(VPV), .BUF_DEPTH(DEP)) u0 (
        .clk(clk), .rst(rst), .query_vnet(query_vnet), .any_free(any_free),
        .sel_valid(sel_valid), .sel_idx(sel_idx), .alloc_req(alloc_req),
        .dec_valid(dec_valid), .dec_vc(dec_vc), .ret_valid(ret_valid),
        .ret_vc(ret_vc), .ret_free(ret_free), .vc_busy(vc_busy),
        .credit_avail(credit_avail), .credit_cnt(credit_cnt), .err(err));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
        alloc_req = 0; dec_valid = 0; ret_valid = 0; ret_free = 0;
    endtask

    function automatic logic [1:0] cnt(input int i);
        return credit_cnt[i*CW +: CW];
    endfunction

    task automatic t_reset();
        rst = 1; tick(); tick(); rst = 0;
        check("R1 busy", vc_busy, 0);
        check("R1 counts", credit_cnt, 8'hFF);
        check("R1 avail", credit_avail, 4'hF);
        check("R1 err", err, 0);
    endtask

    task automatic t_alloc();
        query_vnet = 0; #1;
        check("R3 first pick", {sel_valid, sel_idx}, 3'b100);
        alloc_req = 1; tick();
        check("R4 vc0 busy", vc_busy, 4'b0001);
        query_vnet = 0; #1;
        check("R3 next pick", {sel_valid, sel_idx}, 3'b101);
        alloc_req = 1; tick();
        check("R4 vc1 busy", vc_busy, 4'b0011);
        query_vnet = 0; #1;
        check("R2 vnet0 full", any_free, 0);
        check("R3 none valid", sel_valid, 0);
        query_vnet = 1; #1;
        check("R2 vnet1 free", {any_free, sel_idx}, 3'b110);
        query_vnet = 0; alloc_req = 1; tick();
        check("R4 alloc without valid ignored", vc_busy, 4'b0011);
    endtask

    task automatic t_credits();
        for (int n = 0; n < 3; n++) begin dec_valid = 1; dec_vc = 1; tick(); end
        check("R5 vc1 drained", cnt(1), 0);
        check("R5 avail drops", credit_avail, 4'b1101);
        dec_valid = 1; dec_vc = 1; tick();
        check("R8 underflow holds", cnt(1), 0);
        check("R8 underflow err", err, 1);
        tick();
        check("R8 err one cycle", err, 0);
        ret_valid = 1; ret_vc = 1; ret_free = 0; tick();
        check("R6 return count", cnt(1), 1);
        check("R6 no free keeps busy", vc_busy, 4'b0011);
        ret_valid = 1; ret_vc = 1; ret_free = 1; tick();
        check("R6 free return count", cnt(1), 2);
        check("R6 free clears", vc_busy, 4'b0001);
        query_vnet = 0; #1;
        check("R3 lowest idle", {sel_valid, sel_idx}, 3'b101);
    endtask

    task automatic t_same_cycle();
        dec_valid = 1; dec_vc = 1; ret_valid = 1; ret_vc = 1; tick();
        check("R7 net zero", cnt(1), 2);
        check("R7 no err", err, 0);
        dec_valid = 1; dec_vc = 0; tick();
        check("R5 vc0 debit", cnt(0), 2);
        dec_valid = 1; dec_vc = 0; ret_valid = 1; ret_vc = 0; ret_free = 1; tick();
        check("R7 net zero with free", cnt(0), 2);
        check("R7 free applies", vc_busy, 4'b0000);
    endtask

    task automatic t_bounds();
        ret_valid = 1; ret_vc = 3; tick();
        check("R8 overflow holds", cnt(3), 3);
        check("R8 overflow err", err, 1);
        dec_valid = 1; dec_vc = 2; tick();
        query_vnet = 1; alloc_req = 1; ret_valid = 1; ret_vc = 2; ret_free = 1; tick();
        check("R9 alloc wins", vc_busy, 4'b0100);
        check("R9 count back", cnt(2), 3);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_alloc();
        t_credits();
        t_same_cycle();
        t_bounds();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule